// File: doc/BRIEF.md
# Single-Level Fast Context Shadow

This block keeps a one-deep hidden copy of three processor context registers: the condition flags (5 bits), the accumulator (8 bits) and the bank selector (4 bits). The core pulses a capture strobe when it vectors to an interrupt, from any source. It pulses a separate capture strobe when it executes a subroutine call that asks for context saving. In both cases the block records the live values of all three registers.

A return that asks for restoration pulses the restore strobe. The block then presents the saved values on its restore outputs and raises a valid flag in that same cycle, and the core loads them into its live registers. A plain return uses a separate strobe and has no effect on the block. Software has no path to read or write the stored copy. Because the store is only one level deep, a second capture overwrites the first, for example when a high-priority interrupt arrives while a low-priority handler is running.

Top module: `fast_ctx_shadow`

## Requirements
- R1: After synchronous reset the stored copy is all zeros, so a restore issued right after reset drives flags 0, accumulator 0 and bank 0.
- R2: When `vec_take` is high at a rising clock edge, the store takes the live flags, accumulator and bank values present at that edge.
- R3: When `call_save` is high at a rising clock edge, the store takes the live values in the same way as an interrupt capture.
- R4: While `ret_restore` is high, `restore_valid` is high in the same cycle and the restore outputs equal the stored copy. A restore with no capture leaves the store unchanged, so back-to-back restores return identical values.
- R5: A plain return (`ret_plain` high, with no capture and no restore) keeps `restore_valid` low and the restore outputs at zero, and it leaves the store unchanged.
- R6: Each capture replaces the whole previous content. After two captures, only the second set of values can be restored.
- R7: When a capture and a restore occur in the same cycle, the restore outputs carry the content from before the capture, and the store holds the new live values from the next cycle on.
- R8: While `ret_restore` is low, `restore_valid` is low and all restore outputs are zero.
- R9: In a cycle with neither capture strobe high, the store keeps its content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| live_flags | input | 5 | Current condition flags |
| live_acc | input | 8 | Current accumulator |
| live_bank | input | 4 | Current bank selector |
| vec_take | input | 1 | Interrupt vector capture strobe |
| call_save | input | 1 | Context-saving call capture strobe |
| ret_restore | input | 1 | Context-restoring return strobe |
| ret_plain | input | 1 | Plain return strobe, has no effect |
| restore_valid | output | 1 | Restore outputs are valid this cycle |
| rest_flags | output | 5 | Flags value to restore |
| rest_acc | output | 8 | Accumulator value to restore |
| rest_bank | output | 4 | Bank value to restore |

## Verification
The hardest case to reach is a capture and a restore in the same cycle, where the outputs must show the old content while the store takes the new one. The random stimulus rarely lines up both strobes with distinct live values, so directed steps force this case after a known capture. The same applies to a nested capture that overwrites a saved set before it is restored. Random cycles with sparse strobes then check that the store holds through idle and plain-return cycles, against a model kept in the bench.

// File: rtl/fast_ctx_pkg.sv
package fast_ctx_pkg;

    localparam int FLAGS_W = 5;
    localparam int ACC_W   = 8;
    localparam int BANK_W  = 4;
    localparam int CTX_W   = FLAGS_W + ACC_W + BANK_W;

    typedef struct packed {
        logic [FLAGS_W-1:0] flags;
        logic [ACC_W-1:0]   acc;
        logic [BANK_W-1:0]  bank;
    } ctx_t;

    function automatic ctx_t ctx_make(input logic [FLAGS_W-1:0] f,
                                      input logic [ACC_W-1:0]   a,
                                      input logic [BANK_W-1:0]  b);
        ctx_t c;
        c.flags = f;
        c.acc   = a;
        c.bank  = b;
        return c;
    endfunction

    function automatic ctx_t ctx_zero();
        return ctx_t'('0);
    endfunction

endpackage

// File: rtl/ctx_capture_sel.sv
module ctx_capture_sel
    import fast_ctx_pkg::*;
(
    input  logic vec_take,
    input  logic call_save,
    input  ctx_t live_ctx,
    output logic load_en,
    output ctx_t load_val
);
    // Both capture sources store the same live set; either one fires a load.
    always_comb begin
        load_en  = vec_take | call_save;
        load_val = live_ctx;
    end
endmodule

// File: rtl/ctx_shadow_store.sv
module ctx_shadow_store
    import fast_ctx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_en,
    input  ctx_t load_val,
    output ctx_t held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= ctx_zero();
        end else if (load_en) begin
            held <= load_val;
        end
    end
endmodule

// File: rtl/ctx_restore_drive.sv
module ctx_restore_drive
    import fast_ctx_pkg::*;
(
    input  logic ret_restore,
    input  ctx_t held,
    output logic valid,
    output ctx_t out_ctx
);
    logic [CTX_W-1:0] held_bits;
    logic [CTX_W-1:0] out_bits;

    assign held_bits = held;

    // Per-bit gating: the outputs read zero unless a restore is in progress.
    for (genvar i = 0; i < CTX_W; i++) begin : g_gate
        assign out_bits[i] = held_bits[i] & ret_restore;
    end

    assign valid   = ret_restore;
    assign out_ctx = ctx_t'(out_bits);
endmodule

// File: rtl/fast_ctx_shadow.sv
module fast_ctx_shadow
    import fast_ctx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [FLAGS_W-1:0] live_flags,
    input  logic [ACC_W-1:0]   live_acc,
    input  logic [BANK_W-1:0]  live_bank,
    input  logic               vec_take,
    input  logic               call_save,
    input  logic               ret_restore,
    input  logic               ret_plain,
    output logic               restore_valid,
    output logic [FLAGS_W-1:0] rest_flags,
    output logic [ACC_W-1:0]   rest_acc,
    output logic [BANK_W-1:0]  rest_bank
);
    ctx_t live_ctx;
    ctx_t load_val;
    ctx_t shadow_q;
    ctx_t out_ctx;
    logic load_en;
    logic plain_unused;

    assign live_ctx     = ctx_make(live_flags, live_acc, live_bank);
    // A plain return needs no action here; the strobe is accepted and ignored.
    assign plain_unused = ret_plain;

    ctx_capture_sel u_cap (
        .vec_take (vec_take),
        .call_save(call_save),
        .live_ctx (live_ctx),
        .load_en  (load_en),
        .load_val (load_val)
    );

    ctx_shadow_store u_store (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .load_val(load_val),
        .held    (shadow_q)
    );

    ctx_restore_drive u_rest (
        .ret_restore(ret_restore),
        .held       (shadow_q),
        .valid      (restore_valid),
        .out_ctx    (out_ctx)
    );

    assign rest_flags = out_ctx.flags;
    assign rest_acc   = out_ctx.acc;
    assign rest_bank  = out_ctx.bank;
endmodule

// File: rtl/fast_ctx_shadow_chk.sv
module fast_ctx_shadow_chk
    import fast_ctx_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [FLAGS_W-1:0] live_flags,
    input logic [ACC_W-1:0]   live_acc,
    input logic [BANK_W-1:0]  live_bank,
    input logic               vec_take,
    input logic               call_save,
    input logic               ret_restore,
    input logic               ret_plain,
    input logic               restore_valid,
    input logic [FLAGS_W-1:0] rest_flags,
    input logic [ACC_W-1:0]   rest_acc,
    input logic [BANK_W-1:0]  rest_bank,
    input ctx_t               shadow_q
);
    logic [CTX_W-1:0] live_bits;
    logic [CTX_W-1:0] rest_bits;
    assign live_bits = {live_flags, live_acc, live_bank};
    assign rest_bits = {rest_flags, rest_acc, rest_bank};

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (shadow_q == ctx_zero()));

    p_capture_live_r2: assert property (@(posedge clk) disable iff (rst)
        (vec_take || call_save) |=> (shadow_q == $past(live_bits)));

    p_restore_shows_r4: assert property (@(posedge clk) disable iff (rst)
        ret_restore |-> (restore_valid && rest_bits == shadow_q));

    p_plain_noop_r5: assert property (@(posedge clk) disable iff (rst)
        (ret_plain && !ret_restore && !vec_take && !call_save)
            |=> ($stable(shadow_q)));

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !ret_restore |-> (!restore_valid && rest_bits == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!vec_take && !call_save) |=> $stable(shadow_q));
endmodule

bind fast_ctx_shadow fast_ctx_shadow_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .live_flags   (live_flags),
    .live_acc     (live_acc),
    .live_bank    (live_bank),
    .vec_take     (vec_take),
    .call_save    (call_save),
    .ret_restore  (ret_restore),
    .ret_plain    (ret_plain),
    .restore_valid(restore_valid),
    .rest_flags   (rest_flags),
    .rest_acc     (rest_acc),
    .rest_bank    (rest_bank),
    .shadow_q     (shadow_q)
);

// File: tb/fast_ctx_shadow_tb.sv
`timescale 1ns/1ps
module fast_ctx_shadow_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] live_flags = '0;
    logic [7:0] live_acc = '0;
    logic [3:0] live_bank = '0;
    logic       vec_take = 1'b0;
    logic       call_save = 1'b0;
    logic       ret_restore = 1'b0;
    logic       ret_plain = 1'b0;
    logic       restore_valid;
    logic [4:0] rest_flags;
    logic [7:0] rest_acc;
    logic [3:0] rest_bank;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [16:0] model = '0;

    always #2.5 clk = ~clk;

    fast_ctx_shadow u_dut (
        .clk(clk), .rst(rst),
        .live_flags(live_flags), .live_acc(live_acc), .live_bank(live_bank),
        .vec_take(vec_take), .call_save(call_save),
        .ret_restore(ret_restore), .ret_plain(ret_plain),
        .restore_valid(restore_valid),
        .rest_flags(rest_flags), .rest_acc(rest_acc), .rest_bank(rest_bank)
    );

    function automatic logic [17:0] expect_out(input logic restore, input logic [16:0] m);
        return restore ? {1'b1, m} : 18'd0;
    endfunction

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check outputs, then apply the edge to the model.
    task automatic step(input string req, input logic vt, input logic cs,
                        input logic rr, input logic rp, input logic [16:0] live);
        @(negedge clk);
        {live_flags, live_acc, live_bank} = live;
        vec_take = vt; call_save = cs; ret_restore = rr; ret_plain = rp;
        #1;
        check(req, {restore_valid, rest_flags, rest_acc, rest_bank}, expect_out(rr, model));
        @(posedge clk);
        if (vt || cs) model = live;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = '0;
        // R1: restore right after reset gives zeros
        step("R1", 0, 0, 1, 0, 17'h1ffff);
        // R8: idle outputs zero
        step("R8", 0, 0, 0, 0, 17'h0abcd);
        // R2: interrupt capture then restore
        step("R2", 1, 0, 0, 0, 17'h15a3c);
        step("R2", 0, 0, 1, 0, 17'h00000);
        // R4: second restore returns same values
        step("R4", 0, 0, 1, 0, 17'h1ffff);
        // R3: call capture
        step("R3", 0, 1, 0, 0, 17'h0c3a5);
        step("R3", 0, 0, 1, 0, 17'h12345);
        // R5: plain return no effect
        step("R5", 0, 0, 0, 1, 17'h1f0f0);
        step("R5", 0, 0, 1, 0, 17'h00000);
        // R6: nested capture overwrites
        step("R6", 0, 1, 0, 0, 17'h01111);
        step("R6", 1, 0, 0, 0, 17'h1eeee);
        step("R6", 0, 0, 1, 0, 17'h00000);
        // R7: capture and restore in same cycle
        step("R7", 1, 0, 1, 0, 17'h0b0b0);
        step("R7", 0, 0, 1, 0, 17'h00000);
        // R9: idle cycles hold content
        step("R9", 0, 0, 0, 0, 17'h1aaaa);
        step("R9", 0, 0, 1, 0, 17'h05555);
        // Random mix
        for (int i = 0; i < 400; i++) begin
            int unsigned r;
            logic [16:0] lv;
            r  = $urandom;
            lv = 17'($urandom);
            step("R9", (r % 8) == 0, (r % 11) == 0, (r % 4) == 0, (r % 5) == 0, lv);
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule